// File: doc/BRIEF.md
# Two-Step Cascaded Ripple Counter

This block is a binary up-counter built from a chain of identical toggle cells. Each cell holds two bits: a master and a slave. An increment takes two separate control steps. The load step (`step_a`) writes into every enabled master the inverse of that cell's slave. The commit step (`step_b`) then copies each master into its slave. The count output shows the slave bits, so it stays put through the load step and moves only on the commit step.

All storage is clocked by the system clock. The two step inputs act as synchronous enables, sampled on each rising edge. A cell is enabled when `cnt_en` is high and every lower slave bit is 1. This enable ripples upward from the cells' internal slave state, not from any buffered copy of the output. The chain length is a parameter: five stages by default, for a refresh row counter, with two or three stages as smaller variants. A terminal carry flags the case where the count is all ones while counting is enabled.

Top module: `two_step_counter`

## Requirements
- R1: A synchronous active-low reset clears every master and slave bit. After reset, `count` is 0, and a commit step with no load step keeps it at 0.
- R2: A load step alone (step_a=1, step_b=0) never changes `count` in the following cycle, even when it is repeated over several cycles.
- R3: A commit step alone (step_a=0, step_b=1) copies every master bit into its slave. After a load with `cnt_en`=1, `count` becomes the old count plus 1, modulo 2^STAGES.
- R4: During a load, bit k takes a new value only when `cnt_en` is 1 and all bits below k are 1. Otherwise its master keeps its previous value.
- R5: A load followed by a commit from the all-ones count gives 0.
- R6: A commit step with no load since the previous commit leaves `count` unchanged.
- R7: A load step with `cnt_en`=0 changes no master, so the commit that follows leaves `count` unchanged.
- R8: When step_a and step_b are both 1 in the same cycle, neither master nor slave bits change.
- R9: `carry_out` is 1 exactly when `cnt_en` is 1 and every bit of `count` is 1. It follows `cnt_en` without a clock delay.
- R10: The same behaviour holds for any STAGES of 1 or more, including the 3-stage variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| step_a | input | 1 | Load step: enabled masters take the inverse of their slaves |
| step_b | input | 1 | Commit step: slaves take their masters |
| cnt_en | input | 1 | Count enable feeding the lowest stage of the carry chain |
| count | output | STAGES | Slave bits, least significant stage in bit 0 |
| carry_out | output | 1 | Terminal carry: count all ones while cnt_en is high |

## Verification
The bench builds two copies of the block side by side under the same stimulus: the default 5-stage chain and a 3-stage chain. In the 5-stage copy, 34 increments cover the full 32-value range and one wrap from 31 to 0, with the carry rippling through all five cells. In the 3-stage copy, the same increments cause four wraps, so the all-ones state and the terminal carry are checked many times. Between increments, the bench inserts lone load steps, lone commit steps, steps with the enable low, and clashing steps. This checks that the master and slave stay separate at both widths.

// File: rtl/ripcnt_pkg.sv
// Shared types for the two-step ripple counter.
// Assumes: nothing beyond the 1800-2017 language.
package ripcnt_pkg;

    // Decoded meaning of the two step inputs in one cycle
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LOAD   = 2'd1,
        PH_COMMIT = 2'd2,
        PH_CLASH  = 2'd3
    } phase_e;

    // Storage of one toggle cell
    typedef struct packed {
        logic mst;
        logic slv;
    } cell_t;

endpackage

// File: rtl/ripcnt_step_decode.sv
// Turns the two raw step inputs into one phase code.
// Assumes the step inputs are already synchronous to clk. If both are
// high together, the result is PH_CLASH, which no cell acts on.
module ripcnt_step_decode
    import ripcnt_pkg::*;
(
    input  logic   step_a,
    input  logic   step_b,
    output phase_e phase
);

    // Map the input pair onto a phase code
    always_comb begin
        unique case ({step_b, step_a})
            2'b01:   phase = PH_LOAD;
            2'b10:   phase = PH_COMMIT;
            2'b11:   phase = PH_CLASH;
            default: phase = PH_IDLE;
        endcase
    end

endmodule

// File: rtl/ripcnt_carry.sv
// Ripple enable chain. Stage k is enabled when the count enable is high
// and every lower slave bit is 1. The terminal carry extends the chain by
// one more stage. Assumes its input is the cells' internal slave state.
module ripcnt_carry #(
    parameter int STAGES = 5
) (
    input  logic              cnt_en,
    input  logic [STAGES-1:0] slv,
    output logic [STAGES-1:0] stage_en,
    output logic              term
);

    assign stage_en[0] = cnt_en;

    // One AND link per stage above the first
    for (genvar k = 1; k < STAGES; k++) begin : g_link
        assign stage_en[k] = stage_en[k-1] & slv[k-1];
    end

    assign term = stage_en[STAGES-1] & slv[STAGES-1];

endmodule

// File: rtl/ripcnt_cell.sv
// One master/slave toggle cell. A load writes the inverse of the slave
// into the master; a commit copies the master into the slave.
// Assumes load and commit are never high together (the decoder makes sure).
module ripcnt_cell
    import ripcnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic commit,
    output logic slv
);

    cell_t st;

    // Master and slave update with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= '0;
        end else begin
            if (load)   st.mst <= ~st.slv;
            if (commit) st.slv <= st.mst;
        end
    end

    assign slv = st.slv;

    // R3
    commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (st.slv == $past(st.mst)));

    // R4
    master_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(st.mst));

endmodule

// File: rtl/two_step_counter.sv
// Parameterised ripple counter built from master/slave toggle cells that
// advance in two steps. The count output is the slave bits, so it changes
// only on a commit step. The carry chain is fed from internal slave state.
// Assumes STAGES >= 1 and step inputs synchronous to clk.
module two_step_counter
    import ripcnt_pkg::*;
#(
    parameter int STAGES = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_a,
    input  logic              step_b,
    input  logic              cnt_en,
    output logic [STAGES-1:0] count,
    output logic              carry_out
);

    localparam logic [STAGES-1:0] ONE = STAGES'(1);

    phase_e            phase;
    logic [STAGES-1:0] slv;
    logic [STAGES-1:0] stage_en;
    logic              do_load;
    logic              do_commit;

    ripcnt_step_decode u_dec (
        .step_a (step_a),
        .step_b (step_b),
        .phase  (phase)
    );

    ripcnt_carry #(.STAGES(STAGES)) u_carry (
        .cnt_en   (cnt_en),
        .slv      (slv),
        .stage_en (stage_en),
        .term     (carry_out)
    );

    assign do_load   = (phase == PH_LOAD);
    assign do_commit = (phase == PH_COMMIT);

    // One toggle cell per stage, gated by its ripple enable
    for (genvar k = 0; k < STAGES; k++) begin : g_cell
        ripcnt_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (do_load & stage_en[k]),
            .commit (do_commit),
            .slv    (slv[k])
        );
    end

    assign count = slv;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (count == '0));

    // R2
    load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_a && !step_b) |=> $stable(count));

    // R8
    clash_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_a && step_b) |=> $stable(count));

    // R3
    step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_b && !step_a) |=>
            ((count == $past(count)) || (count == STAGES'($past(count) + ONE))));

    // R9
    carry_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out |-> (cnt_en && (&count)));

endmodule

// File: tb/two_step_counter_test.sv
// Bench: drives a 5-stage and a 3-stage counter with the same steps and
// compares both with a behavioural integer model every cycle.
module two_step_counter_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_a = 1'b0;
    logic       step_b = 1'b0;
    logic       cnt_en = 1'b0;
    logic [4:0] q5;
    logic       tc5;
    logic [2:0] q3;
    logic       tc3;

    int errors = 0;
    int checks = 0;
    int m5_cnt = 0, m5_mst = 0;
    int m3_cnt = 0, m3_mst = 0;
    bit done = 0;

    always #4 clk = ~clk;

    two_step_counter #(.STAGES(5)) uut (
        .clk(clk), .rst_n(rst_n), .step_a(step_a), .step_b(step_b),
        .cnt_en(cnt_en), .count(q5), .carry_out(tc5)
    );

    two_step_counter #(.STAGES(3)) uut3 (
        .clk(clk), .rst_n(rst_n), .step_a(step_a), .step_b(step_b),
        .cnt_en(cnt_en), .count(q3), .carry_out(tc3)
    );

    // New master value after an enabled load: the bits that flip in +1 take the incremented value
    function automatic int load_master(int cnt, int mst, int w);
        int inc  = (cnt + 1) % (1 << w);
        int mask = (cnt ^ inc) & ((1 << w) - 1);
        return (mst & ~mask) | (inc & mask);
    endfunction

    // Reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m5_cnt <= 0; m5_mst <= 0; m3_cnt <= 0; m3_mst <= 0;
        end else if (step_a && !step_b) begin
            if (cnt_en) begin
                m5_mst <= load_master(m5_cnt, m5_mst, 5);
                m3_mst <= load_master(m3_cnt, m3_mst, 3);
            end
        end else if (step_b && !step_a) begin
            m5_cnt <= m5_mst;
            m3_cnt <= m3_mst;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Compare both copies against the model, then drive the next step
    task automatic cyc(bit a, bit b, bit e, string req);
        @(negedge clk);
        chk(req, "count5", int'(q5), m5_cnt);
        chk("R10", "count3", int'(q3), m3_cnt);
        chk("R9", "carry5", int'(tc5), int'(cnt_en && m5_cnt == 31));
        chk("R9", "carry3", int'(tc3), int'(cnt_en && m3_cnt == 7));
        step_a = a;
        step_b = b;
        cnt_en = e;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state, then a lone commit keeps zero
        cyc(0, 0, 1, "R1");
        cyc(0, 0, 1, "R1");
        rst_n = 1'b1;
        cyc(0, 1, 1, "R1");
        cyc(0, 0, 1, "R1");
        cyc(0, 1, 0, "R6");
        cyc(0, 0, 0, "R6");

        // R3 R4 R5: full range with wrap; the idle cycle after each load checks R2
        for (int i = 0; i < 34; i++) begin
            cyc(1, 0, 1, (m5_cnt == 31) ? "R5" : "R4");
            cyc(0, 0, 1, "R2");
            cyc(0, 1, 1, "R3");
            cyc(0, 0, 1, (i == 31) ? "R5" : "R3");
        end

        // R7: load with enable low, then commit: no change
        cyc(1, 0, 0, "R7");
        cyc(0, 1, 0, "R7");
        cyc(0, 0, 1, "R7");

        // R8: clashing steps, then a commit with no load
        cyc(1, 1, 1, "R8");
        cyc(0, 1, 1, "R8");
        cyc(0, 0, 1, "R8");

        // R2: repeated lone loads, no commit, outputs stay put
        cyc(1, 0, 1, "R2");
        cyc(1, 0, 1, "R2");
        cyc(1, 0, 1, "R2");
        cyc(0, 0, 1, "R2");
        cyc(0, 0, 1, "R2");
        cyc(0, 1, 0, "R3");
        cyc(0, 0, 0, "R3");

        // R9: walk to all ones, toggle enable
        while (m5_cnt != 31) begin
            cyc(1, 0, 1, "R4");
            cyc(0, 1, 1, "R4");
        end
        cyc(0, 0, 0, "R9");
        cyc(0, 0, 1, "R9");
        cyc(0, 0, 0, "R9");

        // R1: reset from a non-zero count
        rst_n = 1'b0;
        cyc(0, 0, 1, "R1");
        rst_n = 1'b1;
        cyc(0, 1, 1, "R1");
        cyc(0, 0, 1, "R1");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule